// File: doc/BRIEF.md
# Multichannel Serial ADC Output Framer

This block is the digital output stage of an eight-channel sampling converter. Each channel hands over one parallel sample word per sample period. The block delays every word by a fixed number of samples, then sends it on its own lane as a serial bit stream. All lanes share two companion outputs. The first is a double-data-rate data clock whose edges fall in the middle of each bit. The second is a frame clock that is high for the first half of every word.

The block runs from a half-bit clock, `clk`, with two ticks per serial bit. A one-tick `samp_stb` pulse marks each new sample and starts a frame at the same edge. A frame lasts twice the word length in ticks. Plain configuration pins select:
- the word length, 10 or 12 bits;
- the bit order;
- a constant test word that replaces every sample;
- power-down of individual lanes.

The mode pins are captured at each strobe and hold for the whole frame. Samples pass through unaltered in offset-binary code.

Top module: `serial_adc_framer`

## Requirements
- R1: A strobe starts a frame. The first lane update appears on the tick after the strobe edge. Tick t of the frame (t = 0 .. 2W-1) carries serial bit position k = t/2, so each bit holds for two ticks. W is 10 when `len12`=0 and 12 when `len12`=1, sampled at the strobe.
- R2: With `lsb_first`=0, bit position k carries word bit W-1-k, so the MSB goes first.
- R3: With `lsb_first`=1, bit position k carries word bit k, so the LSB goes first.
- R4: In 12-bit mode the 10-bit sample fills word bits 11..2 and word bits 1..0 are zero.
- R5: `fco` is high on ticks 0 .. W-1 of each frame and low on ticks W .. 2W-1. It only rises on the tick after a strobe.
- R6: On tick t, `dco` equals bit 1 of (t+1). It therefore toggles only on odd ticks, which is mid-bit, and its frequency is half the bit rate.
- R7: The frame started by strobe s (counted from 0 after reset) sends the sample captured at strobe s-8. For s < 8 it sends an all-zero word. Codes pass through unaltered.
- R8: A lane whose `pd_mask` bit is 1 drives 0 on every tick. The other lanes are not affected.
- R9: When `tp_en`=1 at a strobe, every lane sends `tp_word` for that frame. The delay line still stores the sample captured at that strobe and sends it 8 frames later.
- R10: After reset and before the first strobe, `lane_out`, `fco` and `dco` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-bit clock, two ticks per serial bit |
| rst | input | 1 | Synchronous active-high reset |
| samp_stb | input | 1 | One-tick sample strobe; starts a frame |
| samp_data | input | CH_N*SAMP_W | Packed samples, channel c at bits c*SAMP_W +: SAMP_W |
| len12 | input | 1 | 1 selects 12-bit words, 0 selects 10-bit words |
| lsb_first | input | 1 | 1 sends LSB first, 0 sends MSB first |
| tp_en | input | 1 | Replaces all samples with tp_word |
| tp_word | input | SAMP_W | Constant test word |
| pd_mask | input | CH_N | Per-lane power-down |
| lane_out | output | CH_N | Serial data, one bit per lane |
| fco | output | 1 | Frame clock |
| dco | output | 1 | Double-data-rate data clock |

## Verification
The assertions assume that after the first strobe the next strobe comes exactly 2W ticks later, with W the length latched at the previous strobe. They also assume that the mode pins only matter at strobes. The bench drives one strobe at tick 0 of each frame and sizes every frame by its own mode, so strobes never arrive early or late. It sweeps all four length and order combinations, power-down, test-pattern frames and a mid-run reset. Every lane is checked on every tick against words computed from a sample formula.

// File: rtl/sadcf_pkg.sv
package sadcf_pkg;
  localparam int CH_DEF   = 8;
  localparam int SAMP_DEF = 10;
  localparam int EXT_DEF  = 2;
  localparam int LAT_DEF  = 8;
endpackage

// File: rtl/sadcf_lat_pipe.sv
module sadcf_lat_pipe #(
  parameter int W     = 80,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         stb,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp;
  logic [FW-1:0] fill;

  // ring buffer: slot at the write pointer holds the oldest word
  assign dout = (fill == FW'(DEPTH)) ? mem[wp] : '0;

  always_ff @(posedge clk) begin
    if (stb) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp   <= '0;
      fill <= '0;
    end else if (stb) begin
      wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (fill != FW'(DEPTH)) fill <= fill + 1'b1;
    end
  end

  AST_FILL_HOLD: assert property (@(posedge clk) disable iff (rst)
    $past(fill) == FW'(DEPTH) |-> fill == FW'(DEPTH)); // R7
endmodule

// File: rtl/sadcf_frame_timer.sv
module sadcf_frame_timer #(
  parameter int SW  = 10,
  parameter int EXT = 2,
  parameter int TW  = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stb,
  input  logic          len12,
  input  logic          lsb_first,
  output logic          go,
  output logic [TW-1:0] nt,
  output logic          len_now,
  output logic          lsb_now,
  output logic          fco,
  output logic          dco
);
  localparam int LW = SW + EXT;

  logic          started, len_q, lsb_q;
  logic [TW-1:0] tick, last_q, wnow, ntp1;

  assign len_now = stb ? len12 : len_q;
  assign lsb_now = stb ? lsb_first : lsb_q;
  assign go      = started | stb;
  assign last_q  = len_q ? TW'(2*LW - 1) : TW'(2*SW - 1);
  assign wnow    = len_now ? TW'(LW) : TW'(SW);
  assign nt      = stb ? '0 : ((tick == last_q) ? '0 : tick + 1'b1);
  assign ntp1    = nt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      started <= 1'b0;
      tick    <= '0;
      len_q   <= 1'b0;
      lsb_q   <= 1'b0;
      fco     <= 1'b0;
      dco     <= 1'b0;
    end else begin
      if (stb) begin
        started <= 1'b1;
        len_q   <= len12;
        lsb_q   <= lsb_first;
      end
      if (go) tick <= nt;
      fco <= go && (nt < wnow);
      dco <= go && ntp1[1];
    end
  end

  AST_STB_PERIOD: assert property (@(posedge clk) disable iff (rst)
    started && stb |-> tick == last_q); // R1
  AST_FCO_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(fco) |-> $past(stb)); // R5
  AST_DCO_MIDBIT: assert property (@(posedge clk) disable iff (rst)
    !$stable(dco) |-> tick[0]); // R6
endmodule

// File: rtl/sadcf_lane.sv
module sadcf_lane #(
  parameter int SW  = 10,
  parameter int EXT = 2,
  parameter int TW  = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          ld,
  input  logic          len_now,
  input  logic          lsb_now,
  input  logic          pd,
  input  logic [TW-1:0] nt,
  input  logic [SW-1:0] new_word,
  output logic          bit_q
);
  localparam int LW = SW + EXT;
  localparam int IW = $clog2(LW);

  logic [SW-1:0] word_q, wsel;
  logic [LW-1:0] ext;
  logic [IW-1:0] k, wlast, idx;

  assign wsel  = ld ? new_word : word_q;
  assign ext   = len_now ? {wsel, {EXT{1'b0}}} : {{EXT{1'b0}}, wsel};
  assign k     = IW'(nt >> 1);
  assign wlast = len_now ? IW'(LW - 1) : IW'(SW - 1);
  assign idx   = lsb_now ? k : wlast - k;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      bit_q  <= 1'b0;
    end else begin
      if (ld) word_q <= new_word;
      bit_q <= go && !pd && ext[idx];
    end
  end

  AST_PD_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(pd) |-> !bit_q); // R8
endmodule

// File: rtl/serial_adc_framer.sv
module serial_adc_framer
  import sadcf_pkg::*;
#(
  parameter int CH_N    = CH_DEF,
  parameter int SAMP_W  = SAMP_DEF,
  parameter int EXTRA_W = EXT_DEF,
  parameter int LAT     = LAT_DEF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 samp_stb,
  input  logic [CH_N*SAMP_W-1:0] samp_data,
  input  logic                 len12,
  input  logic                 lsb_first,
  input  logic                 tp_en,
  input  logic [SAMP_W-1:0]    tp_word,
  input  logic [CH_N-1:0]      pd_mask,
  output logic [CH_N-1:0]      lane_out,
  output logic                 fco,
  output logic                 dco
);
  localparam int LW = SAMP_W + EXTRA_W;
  localparam int TW = $clog2(2*LW + 1);

  logic [CH_N*SAMP_W-1:0] delayed;
  logic                   go, len_now, lsb_now;
  logic [TW-1:0]          nt;

  sadcf_lat_pipe #(.W(CH_N*SAMP_W), .DEPTH(LAT)) u_pipe (
    .clk(clk), .rst(rst), .stb(samp_stb), .din(samp_data), .dout(delayed)
  );

  sadcf_frame_timer #(.SW(SAMP_W), .EXT(EXTRA_W), .TW(TW)) u_timer (
    .clk(clk), .rst(rst), .stb(samp_stb), .len12(len12), .lsb_first(lsb_first),
    .go(go), .nt(nt), .len_now(len_now), .lsb_now(lsb_now), .fco(fco), .dco(dco)
  );

  for (genvar c = 0; c < CH_N; c++) begin : g_lane
    logic [SAMP_W-1:0] src;
    assign src = tp_en ? tp_word : delayed[c*SAMP_W +: SAMP_W];
    sadcf_lane #(.SW(SAMP_W), .EXT(EXTRA_W), .TW(TW)) u_lane (
      .clk(clk), .rst(rst), .go(go), .ld(samp_stb), .len_now(len_now),
      .lsb_now(lsb_now), .pd(pd_mask[c]), .nt(nt), .new_word(src),
      .bit_q(lane_out[c])
    );
  end
endmodule

// File: tb/serial_adc_framer_tb_top.sv
module serial_adc_framer_tb_top;
  localparam int CH = 8;
  localparam int SW = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             stb = 1'b0;
  logic             len12 = 1'b0, lsbf = 1'b0, tp_en = 1'b0;
  logic [CH*SW-1:0] sdata = '0;
  logic [SW-1:0]    tpw = '0;
  logic [CH-1:0]    pd = '0;
  logic [CH-1:0]    lanes;
  logic             fco, dco;

  int checks = 0, errs = 0, g = 0, base = 0;
  bit done = 0;

  always #5 clk = ~clk;

  serial_adc_framer dut_i (
    .clk(clk), .rst(rst), .samp_stb(stb), .samp_data(sdata), .len12(len12),
    .lsb_first(lsbf), .tp_en(tp_en), .tp_word(tpw), .pd_mask(pd),
    .lane_out(lanes), .fco(fco), .dco(dco)
  );

  function automatic logic [SW-1:0] samp(int n, int ch);
    if (n % 7 == 3) return ch[0] ? 10'h3FF : 10'h000;
    return SW'((n * 37 + ch * 113 + 5) % 1024);
  endfunction

  function automatic logic ebit(logic [SW-1:0] w, bit l12, bit lsb, int t);
    int wl = l12 ? 12 : 10;
    logic [11:0] e = l12 ? {w, 2'b00} : {2'b00, w};
    int k = t / 2;
    int idx = lsb ? k : wl - 1 - k;
    return e[idx];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h (strobe %0d)", tag, act, exp, g);
    end
  endtask

  task automatic run_frame(bit l12, bit lsb, bit tpe, logic [SW-1:0] tv, logic [CH-1:0] pdm);
    int wl = l12 ? 12 : 10;
    logic [CH-1:0] e;
    string tag;
    for (int t = 0; t < 2*wl; t++) begin
      if (t == 0) begin
        stb = 1'b1; len12 = l12; lsbf = lsb; tp_en = tpe; tpw = tv; pd = pdm;
        for (int c = 0; c < CH; c++) sdata[c*SW +: SW] = samp(g, c);
      end else stb = 1'b0;
      @(posedge clk);
      @(negedge clk);
      for (int c = 0; c < CH; c++) begin
        logic [SW-1:0] w;
        w = tpe ? tv : ((g - base >= 8) ? samp(g - 8, c) : '0);
        e[c] = pdm[c] ? 1'b0 : ebit(w, l12, lsb, t);
      end
      if (tpe) tag = "R9 test word";
      else if (pdm != 0) tag = "R8 power-down";
      else if (g - base < 8) tag = "R7 zero fill";
      else if (l12) tag = "R4 12-bit";
      else if (lsb) tag = "R3 lsb-first";
      else tag = "R2 msb-first";
      chk({"R1 ", tag}, 32'(lanes), 32'(e));
      chk("R5 fco", 32'(fco), 32'(t < wl));
      chk("R6 dco", 32'(dco), 32'(((t + 1) / 2) % 2));
    end
    stb = 1'b0;
    g++;
  endtask

  task automatic do_reset();
    rst = 1'b1; stb = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    base = g;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R10 idle after reset", 32'({lanes, fco, dco}), 32'd0);
    end
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    for (int i = 0; i < 10; i++) run_frame(0, 0, 0, '0, '0);
    for (int i = 0; i < 6; i++)  run_frame(0, 1, 0, '0, '0);
    for (int i = 0; i < 6; i++)  run_frame(1, 0, 0, '0, '0);
    for (int i = 0; i < 6; i++)  run_frame(1, 1, 0, '0, '0);
    for (int i = 0; i < 4; i++)  run_frame(0, 0, 0, '0, 8'hA5);
    for (int i = 0; i < 3; i++)  run_frame(1, 1, 0, '0, 8'hA5);
    for (int i = 0; i < 3; i++)  run_frame(0, 0, 1, 10'h2C9, '0);
    for (int i = 0; i < 2; i++)  run_frame(1, 1, 1, 10'h2C9, 8'h0F);
    for (int i = 0; i < 10; i++) run_frame(0, 1, 0, '0, '0);
    do_reset();
    for (int i = 0; i < 10; i++) run_frame(1, 0, 0, '0, '0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog R1 act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end
endmodule